// File: doc/BRIEF.md
# Debounced Level Interrupt Bank

This block watches eight external input pins and turns each of them into a clean, debounced level. Every pin first passes through a two-flop synchronizer. A per-channel filter then accepts a new value only after the pin has held that value for a programmable number of 1 ms ticks, from 1 ms up to 4095 ms. A free-running tick input at 1 kHz, from outside the block, sets the timebase.

Each filtered level is compared with a per-channel polarity bit. While an enabled channel matches its polarity, its raw status bit is set. Software clears status with write-one-to-clear. An enable register masks the raw status, and the masked bits are ORed into one interrupt line. Hardware detects levels only. Software can emulate an edge by inverting the polarity after each event.

An optional single-trigger arm bit limits a channel to one recorded event. The channel records another event only after the arm bit is written to 0 and then set again. All registers are 32-bit words at word-aligned byte offsets on a simple synchronous bus. Writes take effect at the clock edge that samples them. Reads return data combinationally in the same cycle.

Top module: `dbnc_irq_bank`

## Requirements
- R1: After reset every register reads 0 and `irq_out` is 0.
- R2: A channel's filtered level takes a new pin value only after the synchronized pin has differed from the current level for L consecutive tick pulses. L is bits 11:0 of the channel's timing word at byte offset 0x40 + 4*n, and a field of 0 counts as 1. A pulse shorter than L ticks leaves the level unchanged.
- R3: Bit n of the level register (offset 0x00) shows channel n's filtered level only while bit n of the channel enable register (0x04) is 1. A disabled channel reads 0, its filter is held at 0, and it sets no status.
- R4: Bit n of raw status (0x1C) becomes 1 on the clock edge after an enabled channel's filtered level equals its polarity bit (0x14). Polarity 1 means active high and 0 means active low.
- R5: Writing 1 to bit n of the clear register (0x24) clears raw status bit n, and 0 bits have no effect. If the level condition still holds at that edge, the bit stays set. The clear register reads 0.
- R6: Masked status (0x20) equals raw status AND the interrupt enable register (0x18), and `irq_out` is the OR of the masked bits.
- R7: While arm bit n (0x28) is 1, raw status bit n rises at most once. Writing the arm bit to 0 and then to 1 allows one more event.
- R8: Each timing word stores all 32 bits and reads them back unchanged. Bits 31:12 do not affect the debounce time.
- R9: Writes to the level, raw status and masked status offsets are ignored. Reads from unmapped offsets return 0.
- R10: The enable, polarity, interrupt enable and arm registers change only on a bus write to their own offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1khz | input | 1 | One-cycle pulse per millisecond, the debounce timebase |
| pins_in | input | NCH | Asynchronous external inputs, one per channel |
| bus_en | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the cycle of a read access |
| irq_out | output | 1 | OR of the masked status bits |

## Verification
A register write becomes visible at the clock edge that samples it. Read data reflects register state in the same cycle. A raw status bit and `irq_out` follow one edge after the level condition holds. A filtered level moves two synchronizer edges plus L tick pulses after a pin change. The bench drives inputs just after the rising edge and steps a behavioural reference model on that edge. At the falling edge it compares `irq_out` every cycle, and the read data in any cycle that holds a read, with the model. Literal expected values are placed only after waits long enough to cover the synchronizer and the longest tick phase.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;

  // Width of the debounce field inside each timing word.
  localparam int DBNC_W      = 12;
  // Depth of the input synchronizer.
  localparam int SYNC_STAGES = 2;

  // Byte offsets of the register words.
  localparam int OFS_LEVEL = 'h00;
  localparam int OFS_DEN   = 'h04;
  localparam int OFS_POL   = 'h14;
  localparam int OFS_IEN   = 'h18;
  localparam int OFS_RAW   = 'h1C;
  localparam int OFS_MSK   = 'h20;
  localparam int OFS_CLR   = 'h24;
  localparam int OFS_ARM   = 'h28;
  localparam int OFS_TIME  = 'h40;

  // Number of ticks a changed input must persist; a zero field counts as one.
  function automatic logic [DBNC_W:0] dbnc_limit(input logic [DBNC_W-1:0] field);
    return (field == '0) ? (DBNC_W+1)'(1) : {1'b0, field};
  endfunction

endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/dbnc_filter.sv
module dbnc_filter
  import dbnc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              tick,
  input  logic              pin,
  input  logic [DBNC_W-1:0] limit_field,
  output logic              level
);

  logic              pin_s;
  logic              level_q;
  logic [DBNC_W-1:0] cnt_q;
  logic [DBNC_W:0]   need;
  logic              differs;
  logic              reached;

  dbnc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin),
    .q    (pin_s)
  );

  assign need    = dbnc_limit(limit_field);
  assign differs = pin_s ^ level_q;
  assign reached = ({1'b0, cnt_q} + 1'b1) >= need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else if (hold) begin
      level_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (reached) begin
        level_q <= pin_s;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level = level_q;

  // R2: an enabled filter only moves its level on a tick pulse
  p_move_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(hold) && (level_q != $past(level_q))) |-> $past(tick));

  // R3: a held (disabled) filter reports a low level
  p_hold_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !level_q);

endmodule

// File: rtl/dbnc_event.sv
module dbnc_event (
  input  logic clk,
  input  logic rst_n,
  input  logic match,
  input  logic clr,
  input  logic arm,
  output logic raw
);

  logic raw_q;
  logic spent_q;
  logic allow;

  assign allow = !arm || !spent_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= 1'b0;
      spent_q <= 1'b0;
    end else begin
      raw_q   <= (raw_q & ~clr) | (match & allow);
      spent_q <= arm & (spent_q | match);
    end
  end

  assign raw = raw_q;

  // R4: status only rises after the level condition held
  p_needs_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $past(match));

  // R5: a clear with no active condition empties the status bit
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !match) |=> !raw_q);

  // R7: once an armed event is spent, no new rise until re-armed
  p_one_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && spent_q) |=> !$rose(raw_q));

endmodule

// File: rtl/dbnc_csr.sv
module dbnc_csr
  import dbnc_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_en,
  input  logic                         bus_we,
  input  logic [AW-1:0]                bus_addr,
  input  logic [DW-1:0]                bus_wdata,
  output logic [DW-1:0]                bus_rdata,
  input  logic [NCH-1:0]               level,
  input  logic [NCH-1:0]               raw,
  output logic [NCH-1:0]               den,
  output logic [NCH-1:0]               pol,
  output logic [NCH-1:0]               ien,
  output logic [NCH-1:0]               arm,
  output logic [NCH-1:0]               clr_pulse,
  output logic [NCH-1:0][DBNC_W-1:0]   time_field
);

  logic          wr_en;
  logic          rd_en;
  logic [NCH-1:0] time_hit;
  logic [DW-1:0] time_r [NCH];

  assign wr_en = bus_en & bus_we;
  assign rd_en = bus_en & ~bus_we;

  function automatic logic hit(input logic [AW-1:0] a, input int ofs);
    return a == AW'(ofs);
  endfunction

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_time
      assign time_hit[i] = hit(bus_addr, OFS_TIME + 4*i);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     time_r[i] <= '0;
        else if (wr_en && time_hit[i])  time_r[i] <= bus_wdata;
      end

      assign time_field[i] = time_r[i][DBNC_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      den <= '0;
      pol <= '0;
      ien <= '0;
      arm <= '0;
    end else if (wr_en) begin
      if (hit(bus_addr, OFS_DEN)) den <= bus_wdata[NCH-1:0];
      if (hit(bus_addr, OFS_POL)) pol <= bus_wdata[NCH-1:0];
      if (hit(bus_addr, OFS_IEN)) ien <= bus_wdata[NCH-1:0];
      if (hit(bus_addr, OFS_ARM)) arm <= bus_wdata[NCH-1:0];
    end
  end

  assign clr_pulse = (wr_en && hit(bus_addr, OFS_CLR)) ? bus_wdata[NCH-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (hit(bus_addr, OFS_LEVEL))    bus_rdata = DW'(level & den);
      else if (hit(bus_addr, OFS_DEN)) bus_rdata = DW'(den);
      else if (hit(bus_addr, OFS_POL)) bus_rdata = DW'(pol);
      else if (hit(bus_addr, OFS_IEN)) bus_rdata = DW'(ien);
      else if (hit(bus_addr, OFS_RAW)) bus_rdata = DW'(raw);
      else if (hit(bus_addr, OFS_MSK)) bus_rdata = DW'(raw & ien);
      else if (hit(bus_addr, OFS_ARM)) bus_rdata = DW'(arm);
      for (int i = 0; i < NCH; i++) begin
        if (time_hit[i]) bus_rdata = time_r[i];
      end
    end
  end

  // R10: configuration only moves on a bus write
  p_cfg_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(den) && $stable(pol) && $stable(ien) && $stable(arm)));

endmodule

// File: rtl/dbnc_irq_bank.sv
module dbnc_irq_bank
  import dbnc_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_1khz,
  input  logic [NCH-1:0] pins_in,
  input  logic           bus_en,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           irq_out
);

  logic [NCH-1:0]             level;
  logic [NCH-1:0]             raw;
  logic [NCH-1:0]             den;
  logic [NCH-1:0]             pol;
  logic [NCH-1:0]             ien;
  logic [NCH-1:0]             arm;
  logic [NCH-1:0]             clr_pulse;
  logic [NCH-1:0]             match;
  logic [NCH-1:0][DBNC_W-1:0] time_field;

  dbnc_csr #(.NCH(NCH), .AW(AW), .DW(DW)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .level     (level),
    .raw       (raw),
    .den       (den),
    .pol       (pol),
    .ien       (ien),
    .arm       (arm),
    .clr_pulse (clr_pulse),
    .time_field(time_field)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      dbnc_filter u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (~den[i]),
        .tick       (tick_1khz),
        .pin        (pins_in[i]),
        .limit_field(time_field[i]),
        .level      (level[i])
      );

      assign match[i] = den[i] & (level[i] == pol[i]);

      dbnc_event u_event (
        .clk  (clk),
        .rst_n(rst_n),
        .match(match[i]),
        .clr  (clr_pulse[i]),
        .arm  (arm[i]),
        .raw  (raw[i])
      );
    end
  endgenerate

  assign irq_out = |(raw & ien);

endmodule

// File: tb/dbnc_irq_bank_tb.sv
module dbnc_irq_bank_tb;

  localparam int NCH = 8;
  localparam int AW  = 8;
  localparam int DW  = 32;
  localparam int TICK_DIV = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick = 1'b0;
  logic [NCH-1:0] pins = '0;
  logic           bus_en = 1'b0;
  logic           bus_we = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [DW-1:0]  bus_wdata = '0;
  logic [DW-1:0]  bus_rdata;
  logic           irq_out;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  dbnc_irq_bank #(.NCH(NCH), .AW(AW), .DW(DW)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1khz(tick),
    .pins_in  (pins),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq_out  (irq_out)
  );

  // Tick generator: one pulse every TICK_DIV cycles once out of reset.
  int tdiv = 0;
  always @(posedge clk) begin
    #2;
    tdiv = (tdiv + 1) % TICK_DIV;
    tick = (tdiv == 0) && rst_n;
  end

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_en, m_pol, m_ie, m_arm, m_raw, m_spent, m_val, m_p1, m_p2;
  logic [7:0]  m_det, m_clr;
  int          m_cnt [NCH];
  int          m_lim;
  logic [31:0] m_time [NCH];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_pol = 0; m_ie = 0; m_arm = 0; m_raw = 0; m_spent = 0;
      m_val = 0; m_p1 = 0; m_p2 = 0;
      for (int n = 0; n < NCH; n++) begin m_cnt[n] = 0; m_time[n] = 0; end
    end else begin
      m_clr = (bus_en && bus_we && bus_addr == 8'h24) ? bus_wdata[7:0] : 8'h00;
      for (int n = 0; n < NCH; n++) m_det[n] = m_en[n] && (m_val[n] == m_pol[n]);
      for (int n = 0; n < NCH; n++) begin
        if (m_clr[n]) m_raw[n] = 1'b0;
        if (m_det[n] && (!m_arm[n] || !m_spent[n])) m_raw[n] = 1'b1;
        if (!m_arm[n]) m_spent[n] = 1'b0;
        else if (m_det[n]) m_spent[n] = 1'b1;
      end
      for (int n = 0; n < NCH; n++) begin
        m_lim = int'(m_time[n][11:0]);
        if (m_lim == 0) m_lim = 1;
        if (!m_en[n]) begin
          m_val[n] = 1'b0; m_cnt[n] = 0;
        end else if (m_p2[n] == m_val[n]) begin
          m_cnt[n] = 0;
        end else if (tick) begin
          m_cnt[n] = m_cnt[n] + 1;
          if (m_cnt[n] >= m_lim) begin m_val[n] = m_p2[n]; m_cnt[n] = 0; end
        end
      end
      m_p2 = m_p1;
      m_p1 = pins;
      if (bus_en && bus_we) begin
        case (bus_addr)
          8'h04: m_en  = bus_wdata[7:0];
          8'h14: m_pol = bus_wdata[7:0];
          8'h18: m_ie  = bus_wdata[7:0];
          8'h28: m_arm = bus_wdata[7:0];
          default: begin
            if (bus_addr >= 8'h40 && bus_addr < 8'h60 && bus_addr[1:0] == 2'b00)
              m_time[(int'(bus_addr) - 64) / 4] = bus_wdata;
          end
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h00: return {24'h0, m_val & m_en};
      8'h04: return {24'h0, m_en};
      8'h14: return {24'h0, m_pol};
      8'h18: return {24'h0, m_ie};
      8'h1C: return {24'h0, m_raw};
      8'h20: return {24'h0, m_raw & m_ie};
      8'h28: return {24'h0, m_arm};
      default: begin
        if (a >= 8'h40 && a < 8'h60 && a[1:0] == 2'b00) return m_time[(int'(a) - 64) / 4];
        return 32'h0;
      end
    endcase
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk(irq_out === |(m_raw & m_ie), "R6 irq_out", 32'(irq_out), 32'(|(m_raw & m_ie)));
      if (bus_en && !bus_we)
        chk(bus_rdata === m_read(bus_addr), cur_tag, bus_rdata, m_read(bus_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #2;
    cur_tag = tag;
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk); #1;
    chk(bus_rdata === exp, tag, bus_rdata, exp);
    @(posedge clk); #2;
    bus_en = 1'b0;
  endtask

  task automatic set_pin(input int n, input logic v);
    @(posedge clk); #2;
    pins[n] = v;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state
    rd_exp(8'h00, 32'h0, "R1 level");
    rd_exp(8'h04, 32'h0, "R1 den");
    rd_exp(8'h14, 32'h0, "R1 pol");
    rd_exp(8'h18, 32'h0, "R1 ien");
    rd_exp(8'h1C, 32'h0, "R1 raw");
    rd_exp(8'h20, 32'h0, "R1 masked");
    rd_exp(8'h28, 32'h0, "R1 arm");
    rd_exp(8'h40, 32'h0, "R1 time0");
    chk(irq_out === 1'b0, "R1 irq", 32'(irq_out), 32'h0);

    // R8: full word stored, field 3 with upper bits set
    wr(8'h40, 32'hABCDE003);
    rd_exp(8'h40, 32'hABCDE003, "R8 time0 readback");
    wr(8'h14, 32'h01);
    wr(8'h18, 32'h01);
    wr(8'h04, 32'h01);
    set_pin(0, 1'b1);
    wait_cyc(40);
    rd_exp(8'h00, 32'h1, "R2 ch0 settled high");
    rd_exp(8'h1C, 32'h1, "R4 ch0 active high");
    rd_exp(8'h20, 32'h1, "R6 ch0 masked");
    chk(irq_out === 1'b1, "R6 irq high", 32'(irq_out), 32'h1);

    // R5: clear while level persists keeps the bit
    wr(8'h24, 32'h01);
    rd_exp(8'h1C, 32'h1, "R5 clear while active");
    // emulate an edge: invert polarity, then clear
    wr(8'h14, 32'h00);
    wr(8'h24, 32'h01);
    rd_exp(8'h1C, 32'h0, "R5 clear after flip");
    rd_exp(8'h24, 32'h0, "R5 clear reads zero");
    set_pin(0, 1'b0);
    wait_cyc(40);
    rd_exp(8'h1C, 32'h1, "R4 ch0 active low");
    wr(8'h04, 32'h00);
    wr(8'h24, 32'h01);
    rd_exp(8'h1C, 32'h0, "R3 disabled ch0 cleared");

    // R3: disabled channel stays silent
    wr(8'h14, 32'h08);
    set_pin(3, 1'b1);
    wait_cyc(40);
    rd_exp(8'h00, 32'h0, "R3 disabled level");
    rd_exp(8'h1C, 32'h0, "R3 disabled raw");

    // R2: glitch shorter than the debounce time is rejected
    wr(8'h44, 32'h4);
    wr(8'h14, 32'h0A);
    wr(8'h04, 32'h02);
    set_pin(1, 1'b1);
    wait_cyc(10);
    set_pin(1, 1'b0);
    wait_cyc(40);
    rd_exp(8'h00, 32'h0, "R2 glitch rejected");
    set_pin(1, 1'b1);
    wait_cyc(40);
    rd_exp(8'h00, 32'h2, "R2 ch1 settled");

    // R2: zero field acts as one tick
    wr(8'h48, 32'h0);
    wr(8'h14, 32'h0E);
    wr(8'h04, 32'h06);
    set_pin(2, 1'b1);
    wait_cyc(15);
    rd_exp(8'h00, 32'h6, "R2 zero field");

    // R7: single-trigger
    wr(8'h14, 32'h1E);
    wr(8'h28, 32'h10);
    wr(8'h04, 32'h16);
    set_pin(4, 1'b1);
    wait_cyc(40);
    rd_exp(8'h1C, 32'h16, "R7 first event");
    wr(8'h24, 32'h10);
    wait_cyc(5);
    rd_exp(8'h1C, 32'h06, "R7 no second event");
    wr(8'h28, 32'h00);
    wr(8'h28, 32'h10);
    wait_cyc(3);
    rd_exp(8'h1C, 32'h16, "R7 re-armed");

    // R9: read-only offsets ignore writes; unmapped reads zero
    wr(8'h00, 32'hFF);
    wr(8'h1C, 32'h00);
    wr(8'h20, 32'h00);
    rd_exp(8'h1C, 32'h16, "R9 raw unchanged");
    rd_exp(8'h30, 32'h0, "R9 unmapped");
    rd_exp(8'h00, 32'h16, "R9 level unchanged");
    rd_exp(8'h14, 32'h1E, "R10 pol unchanged");

    // R2: maximum field 4095 ticks
    wr(8'h54, 32'h0000_0FFF);
    wr(8'h14, 32'h3E);
    wr(8'h04, 32'h36);
    set_pin(5, 1'b1);
    wait_cyc(20400);
    rd_exp(8'h00, 32'h16, "R2 max field not yet");
    wait_cyc(120);
    rd_exp(8'h00, 32'h36, "R2 max field settled");

    finish_run();
  end

endmodule